// File: doc/BRIEF.md
# Carry-Save Feedback Multiply-Accumulator

This block sums a short run of signed 16-bit by 16-bit products into a 34-bit running total. Each product is formed from radix-4 Booth-recoded partial products. Those partial products enter one carry-save compression tree together with the stored total, so the total never passes through a carry-propagate adder inside the loop. The total is held as a pair of sum and carry vectors. Before they are stored, a small adder settles the lowest bits of that pair, which leaves a shorter adder to produce the binary result at the output.

A caller presents an operand pair with `in_valid` high for one cycle per term. On the clock edge that accepts the term, the running total moves forward, and the resolved result can be read in the following cycle. The sequence closes when the eighth term is accepted, or earlier when a term arrives with `in_last` high. At that point `acc_done` rises and stays high, and further terms are dropped until `acc_clear` starts a new sequence.

Top module: `csa_mac`

## Requirements
- R1: After a reset (`rst_n` low at a rising edge), `acc_result` is 0 and `acc_done` is 0.
- R2: One accepted term with `in_last` high leaves `acc_result` equal to the signed product `op_a*op_b`, written in 34-bit two's complement. `acc_done` is 1 in the cycle after that edge.
- R3: Over a sequence of accepted terms, `acc_result` equals the sum of their signed products modulo 2^34. The value is readable in the cycle after each accepting edge.
- R4: The most negative operand values and the largest positive ones give exact products. For example, -32768*-32768 gives 2^30 and 32767*-32768 gives -1073709056.
- R5: The edge that accepts the eighth term of a sequence raises `acc_done`, even when `in_last` is 0.
- R6: A term accepted with `in_last` high raises `acc_done` at that edge, whatever the count of terms so far (one to eight).
- R7: At an edge where `in_valid` is 0, the total is left unchanged, whatever `op_a` and `op_b` hold.
- R8: While `acc_done` is 1, terms with `in_valid` high are dropped. `acc_result` and `acc_done` stay unchanged until a clear.
- R9: `acc_clear` high at an edge sets `acc_result` to 0 and `acc_done` to 0. It takes priority over a term presented at the same edge.
- R10: Sequences that produce carries out of the bits settled early (including alternating positive and negative products) still give the exact sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_clear | input | 1 | Zeroes the total and ends the done state |
| in_valid | input | 1 | Presents one term to the accumulator |
| in_last | input | 1 | Marks the presented term as the final one of its sequence |
| op_a | input | 16 | Multiplicand, signed two's complement |
| op_b | input | 16 | Multiplier, signed two's complement |
| acc_result | output | 34 | Resolved running total, signed two's complement |
| acc_done | output | 1 | High once the sequence has closed |

## Verification
The operands are chosen to exercise each Booth digit value, including the extreme negative operand that needs the shifted-and-negated multiple. Runs of random length from one to eight pairs are compared with a reference sum; these catch errors in sum and carry feedback that one product alone would hide. Mixed-sign runs and runs of small positive and negative values force carries across the bits that are settled early and across the full 34-bit width. Idle cycles holding live operand values, terms sent after done, and a clear on the same edge as a term show whether the acceptance gating and its priority are correct.

// File: rtl/csa_mac_pkg.sv
package csa_mac_pkg;

   typedef enum logic [2:0] {
      DIG_ZERO,
      DIG_POS1,
      DIG_POS2,
      DIG_NEG1,
      DIG_NEG2
   } booth_dig_t;

   // Radix-4 recoding of one overlapping triplet {high, mid, low}
   function automatic booth_dig_t recode(input logic [2:0] trip);
      booth_dig_t d;
      unique case (trip)
         3'b001, 3'b010: d = DIG_POS1;
         3'b011:         d = DIG_POS2;
         3'b100:         d = DIG_NEG2;
         3'b101, 3'b110: d = DIG_NEG1;
         default:        d = DIG_ZERO;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
   import csa_mac_pkg::*;
#(
   parameter int OP_W  = 16,
   parameter int ACC_W = 34,
   localparam int NPP  = OP_W / 2
) (
   input  logic [OP_W-1:0]             mcand,
   input  logic [OP_W-1:0]             mplier,
   output logic [NPP-1:0][ACC_W-1:0]   pp
);

   if ((OP_W % 2) != 0) begin : g_bad_op_w
      $error("booth_pp_gen: OP_W must be even");
   end

   logic [ACC_W-1:0] ext1;
   logic [ACC_W-1:0] ext2;

   assign ext1 = {{(ACC_W-OP_W){mcand[OP_W-1]}}, mcand};
   assign ext2 = ext1 << 1;

   for (genvar j = 0; j < NPP; j++) begin : g_row
      logic [2:0]       trip;
      logic [ACC_W-1:0] mult;

      if (j == 0) begin : g_first
         assign trip = {mplier[1], mplier[0], 1'b0};
      end else begin : g_rest
         assign trip = mplier[2*j+1 : 2*j-1];
      end

      always_comb begin
         unique case (recode(trip))
            DIG_POS1: mult = ext1;
            DIG_POS2: mult = ext2;
            DIG_NEG1: mult = ~ext1 + 1'b1;
            DIG_NEG2: mult = ~ext2 + 1'b1;
            default:  mult = '0;
         endcase
      end

      assign pp[j] = mult << (2*j);
   end

endmodule

// File: rtl/csa_tree.sv
module csa_tree #(
   parameter int W = 34,
   parameter int N = 11
) (
   input  logic [N-1:0][W-1:0] ops,
   output logic [W-1:0]        sum_o,
   output logic [W-1:0]        carry_o
);

   if (N < 3) begin : g_bad_n
      $error("csa_tree: needs at least three operands");
   end

   logic [N-2:0][W-1:0] s;
   logic [N-2:0][W-1:0] c;

   assign s[0] = ops[0];
   assign c[0] = ops[1];

   for (genvar i = 1; i <= N-2; i++) begin : g_stage
      logic [W-1:0] x;
      assign x    = ops[i+1];
      assign s[i] = s[i-1] ^ c[i-1] ^ x;
      assign c[i] = ((s[i-1] & c[i-1]) | (s[i-1] & x) | (c[i-1] & x)) << 1;
   end

   assign sum_o   = s[N-2];
   assign carry_o = c[N-2];

endmodule

// File: rtl/mac_final_add.sv
module mac_final_add #(
   parameter int W = 34,
   parameter int E = 2
) (
   input  logic [W-1:0] sum_i,
   input  logic [W-1:0] carry_i,
   input  logic         cin_i,
   output logic [W-1:0] value_o
);

   localparam int HI_W = W - E;

   logic [HI_W-1:0] hi;

   assign hi      = sum_i[W-1:E] + carry_i[W-1:E] + HI_W'(cin_i);
   assign value_o = {hi, sum_i[E-1:0]};

endmodule

// File: rtl/csa_mac.sv
module csa_mac
   import csa_mac_pkg::*;
#(
   parameter int OP_W      = 16,
   parameter int ACC_W     = 34,
   parameter int MAX_TERMS = 8,
   parameter int EARLY_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_clear,
   input  logic             in_valid,
   input  logic             in_last,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   output logic [ACC_W-1:0] acc_result,
   output logic             acc_done
);

   localparam int NPP   = OP_W / 2;
   localparam int NIN   = NPP + 3;
   localparam int CNT_W = $clog2(MAX_TERMS + 1);

   if (ACC_W < 2*OP_W) begin : g_bad_acc_w
      $error("csa_mac: ACC_W must hold a full product");
   end
   if (EARLY_W < 1 || EARLY_W >= ACC_W) begin : g_bad_early_w
      $error("csa_mac: EARLY_W out of range");
   end
   if (MAX_TERMS < 1) begin : g_bad_terms
      $error("csa_mac: MAX_TERMS must be positive");
   end

   logic [ACC_W-1:0]          sum_q, carry_q;
   logic                      cin_q;
   logic [CNT_W-1:0]          count_q;
   logic                      done_q;

   logic [NPP-1:0][ACC_W-1:0] pp;
   logic [NIN-1:0][ACC_W-1:0] tree_in;
   logic [ACC_W-1:0]          tree_s, tree_c;
   logic [EARLY_W:0]          low_add;
   logic                      accept;
   logic                      close_seq;

   booth_pp_gen #(.OP_W(OP_W), .ACC_W(ACC_W)) u_pp (
      .mcand  (op_a),
      .mplier (op_b),
      .pp     (pp)
   );

   for (genvar k = 0; k < NPP; k++) begin : g_tree_in
      assign tree_in[k] = pp[k];
   end
   assign tree_in[NPP]   = sum_q;
   assign tree_in[NPP+1] = carry_q;
   assign tree_in[NPP+2] = ACC_W'(cin_q) << EARLY_W;

   csa_tree #(.W(ACC_W), .N(NIN)) u_tree (
      .ops     (tree_in),
      .sum_o   (tree_s),
      .carry_o (tree_c)
   );

   // settle the lowest bits of the pair before storing it
   assign low_add = {1'b0, tree_s[EARLY_W-1:0]} + {1'b0, tree_c[EARLY_W-1:0]};

   assign accept    = in_valid && !done_q && !acc_clear;
   assign close_seq = in_last || (count_q == CNT_W'(MAX_TERMS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || acc_clear) begin
         sum_q   <= '0;
         carry_q <= '0;
         cin_q   <= 1'b0;
         count_q <= '0;
         done_q  <= 1'b0;
      end else if (accept) begin
         sum_q   <= {tree_s[ACC_W-1:EARLY_W], low_add[EARLY_W-1:0]};
         carry_q <= {tree_c[ACC_W-1:EARLY_W], {EARLY_W{1'b0}}};
         cin_q   <= low_add[EARLY_W];
         count_q <= count_q + 1'b1;
         done_q  <= close_seq;
      end
   end

   mac_final_add #(.W(ACC_W), .E(EARLY_W)) u_final (
      .sum_i   (sum_q),
      .carry_i (carry_q),
      .cin_i   (cin_q),
      .value_o (acc_result)
   );

   assign acc_done = done_q;

   AST_RESET_CLEAN: assert property (@(posedge clk)
      !rst_n |=> (acc_result == '0) && !acc_done);  // R1

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_clear |=> (acc_result == '0) && !acc_done);  // R9

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !acc_clear) |=> $stable(acc_result) && $stable(acc_done));  // R7

   AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_done && !acc_clear) |=> acc_done && $stable(acc_result));  // R8

   AST_EIGHTH_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !acc_done && !acc_clear && count_q == CNT_W'(MAX_TERMS - 1))
      |=> acc_done);  // R5

   AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last && !acc_done && !acc_clear) |=> acc_done);  // R6

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(MAX_TERMS));  // R5

endmodule

// File: tb/test_csa_mac.sv
module test_csa_mac;

   localparam int OP_W  = 16;
   localparam int ACC_W = 34;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acc_clear = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_last = 1'b0;
   logic [OP_W-1:0]  op_a = '0;
   logic [OP_W-1:0]  op_b = '0;
   logic [ACC_W-1:0] acc_result;
   logic             acc_done;

   int     n_checks = 0;
   int     n_errors = 0;
   longint ref_sum  = 0;
   bit     finished = 0;

   always #10 clk = ~clk;  // 50 MHz

   csa_mac i_csa_mac (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_clear  (acc_clear),
      .in_valid   (in_valid),
      .in_last    (in_last),
      .op_a       (op_a),
      .op_b       (op_b),
      .acc_result (acc_result),
      .acc_done   (acc_done)
   );

   task automatic check_val(input string req, input logic [ACC_W-1:0] got,
                            input logic [ACC_W-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: result actual=%0d expected=%0d", req,
                  $signed(got), $signed(exp));
      end
   endtask

   task automatic check_bit(input string req, input logic got, input logic exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: done actual=%0b expected=%0b", req, got, exp);
      end
   endtask

   // one term, driven at a falling edge, taken at the next rising edge
   task automatic push(input logic signed [OP_W-1:0] a,
                       input logic signed [OP_W-1:0] b, input logic last);
      op_a     = a;
      op_b     = b;
      in_valid = 1'b1;
      in_last  = last;
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic do_clear();
      acc_clear = 1'b1;
      @(negedge clk);
      acc_clear = 1'b0;
      ref_sum   = 0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_val("R1", acc_result, '0);
      check_bit("R1", acc_done, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_single();
      do_clear();
      push(-16'sd1234, 16'sd567, 1'b1);
      check_val("R2", acc_result, ACC_W'(-64'sd1234 * 64'sd567));
      check_bit("R2", acc_done, 1'b1);
   endtask

   task automatic t_corners();
      do_clear();
      push(-16'sd32768, -16'sd32768, 1'b1);
      check_val("R4", acc_result, ACC_W'(64'sd1073741824));
      do_clear();
      push(16'sd32767, -16'sd32768, 1'b1);
      check_val("R4", acc_result, ACC_W'(-64'sd1073709056));
      do_clear();
      push(16'sd32767, 16'sd32767, 1'b0);
      push(-16'sd32768, 16'sd21845, 1'b1);
      check_val("R4", acc_result,
                ACC_W'(64'sd32767*64'sd32767 + -64'sd32768*64'sd21845));
   endtask

   task automatic t_random_runs();
      for (int r = 0; r < 12; r++) begin
         int len;
         do_clear();
         len = 1 + int'($urandom % 8);
         for (int k = 0; k < len; k++) begin
            logic signed [OP_W-1:0] a, b;
            a = OP_W'($urandom);
            b = OP_W'($urandom);
            ref_sum += longint'(a) * longint'(b);
            push(a, b, k == len - 1);
            check_val("R3", acc_result, ACC_W'(ref_sum));
         end
         check_bit("R6", acc_done, 1'b1);
      end
   endtask

   task automatic t_eight_closes();
      do_clear();
      for (int k = 0; k < 8; k++) begin
         logic signed [OP_W-1:0] a;
         a = -16'sd32768;
         ref_sum += longint'(a) * longint'(a);
         push(a, a, 1'b0);
         check_bit("R5", acc_done, k == 7);
      end
      check_val("R5", acc_result, ACC_W'(ref_sum));
   endtask

   task automatic t_idle_ignored();
      do_clear();
      push(16'sd300, 16'sd7, 1'b0);
      op_a = 16'h7fff;
      op_b = 16'h8000;
      in_last = 1'b1;
      @(negedge clk);
      @(negedge clk);
      in_last = 1'b0;
      check_val("R7", acc_result, ACC_W'(64'sd2100));
      check_bit("R7", acc_done, 1'b0);
   endtask

   task automatic t_after_done();
      do_clear();
      push(16'sd11, -16'sd13, 1'b1);
      push(16'sd1000, 16'sd1000, 1'b0);
      push(-16'sd5, 16'sd5, 1'b1);
      check_val("R8", acc_result, ACC_W'(-64'sd143));
      check_bit("R8", acc_done, 1'b1);
   endtask

   task automatic t_clear_priority();
      push(16'sd50, 16'sd50, 1'b0);
      op_a      = 16'sd99;
      op_b      = 16'sd99;
      in_valid  = 1'b1;
      in_last   = 1'b1;
      acc_clear = 1'b1;
      @(negedge clk);
      in_valid  = 1'b0;
      in_last   = 1'b0;
      acc_clear = 1'b0;
      ref_sum   = 0;
      check_val("R9", acc_result, '0);
      check_bit("R9", acc_done, 1'b0);
   endtask

   task automatic t_low_carries();
      do_clear();
      for (int k = 0; k < 8; k++) begin
         logic signed [OP_W-1:0] a, b;
         a = (k % 2 == 0) ? 16'sd3 : -16'sd1;
         b = (k % 3 == 0) ? 16'sd7 : -16'sd1;
         ref_sum += longint'(a) * longint'(b);
         push(a, b, 1'b0);
         check_val("R10", acc_result, ACC_W'(ref_sum));
      end
      do_clear();
      push(-16'sd1, 16'sd1, 1'b0);
      push(16'sd1, 16'sd1, 1'b1);
      check_val("R10", acc_result, '0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_single();
      t_corners();
      t_random_runs();
      t_eight_closes();
      t_idle_ignored();
      t_after_done();
      t_clear_priority();
      t_low_carries();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule